// File: doc/BRIEF.md
# Four-Way Cache Tag Directory

This block holds the tags and the line state for a four-way set-associative data cache of 256 sets, addressed with a 32-bit byte address. A lookup presents an address together with two flags: one marks the access as a write, and the other marks the target region as copyback rather than write-through. The block splits the address into a 20-bit tag, an 8-bit set index and a 4-bit line offset. It compares the tag against all four stored tags of the selected set at once. One cycle later it reports whether the access hit, which way hit, in one-hot and in encoded form, and whether that line is modified.

A write that hits is absorbed in place. For a copyback region the line is marked modified. For a write-through region the modified bit is left as it was, because the data also goes on to memory. A write hit never causes a refill.

A separate fill port installs a new tag into a way that an external victim selector has chosen. A filled line is valid and clean. An invalidate-all pulse clears the valid and modified bits of every line, one set per cycle. While that sweep runs, both request channels are held off.

The lookup and fill channels are valid/ready. A request is accepted on a cycle where both valid and ready are high. A requester must keep its valid and payload steady until it is accepted.

Both ready signals are low while the sweep is busy. The fill ready is also low whenever a lookup is being offered, so a lookup wins a same-cycle contest. The response is a single-cycle pulse with no back-pressure, so the consumer must take it in the cycle it appears.

Top module: `cache_tag_dir`

## Requirements
- R1: The set is chosen by address bits [11:4]. Bits [3:0] (longword and byte within the 16-byte line) have no effect on the lookup result, and a line filled in one set is not found through any other set index.
- R2: The stored and compared tag is address bits [31:12]. A lookup whose tag differs from every stored tag in the set, even in a single bit, misses.
- R3: A way hits only when its tag matches and its valid bit is 1. `rsp_hit` is the OR of the four per-way hits, and each of the four ways of a set can be hit independently.
- R4: A lookup accepted on a clock edge produces `rsp_valid` high for exactly the following cycle. On a hit, `rsp_way_oh` has exactly the bit for the hit way set (bit n = way n), and `rsp_way` holds n. On a miss both are zero.
- R5: An accepted fill writes `fill_addr[31:12]` into way `fill_way` of set `fill_addr[11:4]`, with valid set to 1 and modified set to 0. This also cleans a line that was modified before.
- R6: A write hit in a copyback region (`lk_copyback`=1) sets the line's modified bit to 1. The same response already reports `rsp_dirty`=1, and later lookups keep reporting it.
- R7: A write hit in a write-through region (`lk_copyback`=0) leaves the modified bit unchanged, whether it was 0 or 1.
- R8: A write that misses changes no line state: a later lookup of that address still misses.
- R9: A one-cycle `inv_all` pulse, taken while not busy, raises `busy` for exactly 256 cycles. During those cycles `lk_ready` and `fill_ready` are 0. Afterwards every line is invalid and clean.
- R10: After reset every line is invalid, `busy` is 0, `rsp_valid` is 0 and `lk_ready` is 1.
- R11: `fill_ready` is 0 in any cycle where `lk_valid` is 1, so a lookup takes precedence over a fill offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request offered |
| lk_ready | output | 1 | Lookup can be accepted (not sweeping) |
| lk_addr | input | 32 | Lookup byte address |
| lk_write | input | 1 | Lookup is a write access |
| lk_copyback | input | 1 | Target region is copyback (1) or write-through (0) |
| rsp_valid | output | 1 | Lookup result valid, one cycle after acceptance |
| rsp_hit | output | 1 | Lookup hit in some way |
| rsp_way_oh | output | 4 | One-hot hit way |
| rsp_way | output | 2 | Encoded hit way |
| rsp_dirty | output | 1 | Modified bit of the hit way after the access |
| fill_valid | input | 1 | Fill request offered |
| fill_ready | output | 1 | Fill can be accepted |
| fill_addr | input | 32 | Address of the line being installed |
| fill_way | input | 2 | Way chosen by the external selector |
| inv_all | input | 1 | Start clearing every line |
| busy | output | 1 | Invalidate sweep in progress |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 256 sets and four ways. With these values the highest set index and the all-ones tag can be reached, and the invalidate sweep has to cover its full 256-cycle length. A single set can also be filled in every way, so each hit position of the one-hot and encoded outputs is exercised. Because the field split is fixed at bits [31:12], [11:4] and [3:0], changing one tag bit, one index bit or the offset bits each tests a separate field boundary.

// File: rtl/tag_dir_pkg.sv
package tag_dir_pkg;
  // Default geometry of the directory
  localparam int unsigned TD_ADDR_W   = 32;
  localparam int unsigned TD_SETS     = 256;
  localparam int unsigned TD_WAYS     = 4;
  localparam int unsigned TD_OFFSET_W = 4;
  // Number of sets cleared by one invalidate-all sweep step
  localparam int unsigned TD_SWEEP_STEP = 1;
endpackage

// File: rtl/tag_way_bank.sv
// Storage for one way: tag, valid and modified bit per set.
module tag_way_bank #(
  parameter int unsigned SETS    = 256,
  parameter int unsigned INDEX_W = 8,
  parameter int unsigned TAG_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_valid,
  output logic               rd_dirty,
  input  logic               fill_en,
  input  logic [INDEX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               mark_en,
  input  logic [INDEX_W-1:0] mark_idx,
  input  logic               clr_en,
  input  logic [INDEX_W-1:0] clr_idx
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (clr_en) begin
      valid_q[clr_idx] <= 1'b0;
      dirty_q[clr_idx] <= 1'b0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= 1'b0;
    end else if (mark_en) begin
      dirty_q[mark_idx] <= 1'b1;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
endmodule

// File: rtl/tag_match.sv
// Parallel compare of all ways against the request tag, plus encoding.
module tag_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0]            way_dirty,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_oh,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       hit_dirty
);
  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_cmp
      assign hit_oh[gw] = way_valid[gw] && (way_tag[gw] == req_tag);
    end
  endgenerate

  assign hit = |hit_oh;

  always_comb begin
    hit_way   = '0;
    hit_dirty = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_oh[w]) begin
        hit_way   = hit_way | WAY_W'(w);
        hit_dirty = hit_dirty | way_dirty[w];
      end
    end
  end
endmodule

// File: rtl/inv_sweeper.sv
// Walks all set indices, one per cycle, after a start pulse.
module inv_sweeper #(
  parameter int unsigned SETS    = 256,
  parameter int unsigned INDEX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               clr_en,
  output logic [INDEX_W-1:0] clr_idx
);
  localparam logic [INDEX_W-1:0] LAST = INDEX_W'(SETS - 1);

  logic [INDEX_W-1:0] cnt_q;
  logic               busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy    = busy_q;
  assign clr_en  = busy_q;
  assign clr_idx = cnt_q;
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import tag_dir_pkg::*;
#(
  parameter int unsigned ADDR_W   = TD_ADDR_W,
  parameter int unsigned SETS     = TD_SETS,
  parameter int unsigned WAYS     = TD_WAYS,
  parameter int unsigned OFFSET_W = TD_OFFSET_W,
  localparam int unsigned INDEX_W = $clog2(SETS),
  localparam int unsigned TAG_W   = ADDR_W - INDEX_W - OFFSET_W,
  localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_write,
  input  logic              lk_copyback,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAYS-1:0]   rsp_way_oh,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_dirty,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              inv_all,
  output logic              busy
);
  // Address field split
  logic [INDEX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0]   lk_tag, fl_tag;
  assign lk_idx = lk_addr[OFFSET_W +: INDEX_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign fl_idx = fill_addr[OFFSET_W +: INDEX_W];
  assign fl_tag = fill_addr[ADDR_W-1 -: TAG_W];

  // Handshakes: sweep blocks both, lookup beats fill
  logic lk_fire, fill_fire;
  assign lk_ready   = !busy;
  assign fill_ready = !busy && !lk_valid;
  assign lk_fire    = lk_valid && lk_ready;
  assign fill_fire  = fill_valid && fill_ready;

  // Invalidate sweep
  logic               clr_en;
  logic [INDEX_W-1:0] clr_idx;
  inv_sweeper #(.SETS(SETS), .INDEX_W(INDEX_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(inv_all),
    .busy(busy), .clr_en(clr_en), .clr_idx(clr_idx)
  );

  // Way banks
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0]            way_valid, way_dirty;
  logic [WAYS-1:0]            hit_oh;
  logic                       hit, hit_dirty;
  logic [WAY_W-1:0]           hit_way;
  logic                       mark_req;

  assign mark_req = lk_fire && lk_write && lk_copyback;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      tag_way_bank #(.SETS(SETS), .INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_tag   (way_tag[gw]),
        .rd_valid (way_valid[gw]),
        .rd_dirty (way_dirty[gw]),
        .fill_en  (fill_fire && (fill_way == WAY_W'(gw))),
        .fill_idx (fl_idx),
        .fill_tag (fl_tag),
        .mark_en  (mark_req && hit_oh[gw]),
        .mark_idx (lk_idx),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx)
      );
    end
  endgenerate

  tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tag(way_tag), .way_valid(way_valid), .way_dirty(way_dirty),
    .req_tag(lk_tag), .hit_oh(hit_oh), .hit(hit),
    .hit_way(hit_way), .hit_dirty(hit_dirty)
  );

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way_oh <= '0;
      rsp_way    <= '0;
      rsp_dirty  <= 1'b0;
    end else begin
      rsp_valid <= lk_fire;
      if (lk_fire) begin
        rsp_hit    <= hit;
        rsp_way_oh <= hit_oh;
        rsp_way    <= hit_way;
        rsp_dirty  <= hit && (hit_dirty || (lk_write && lk_copyback));
      end
    end
  end
endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             fill_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [WAYS-1:0]  rsp_way_oh,
  input logic [WAY_W-1:0] rsp_way,
  input logic             rsp_dirty,
  input logic             inv_all,
  input logic             busy
);
  // R4
  single_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_way_oh));
  // R4
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);
  // R4
  rsp_only_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(lk_valid && lk_ready));
  // R4
  way_code_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> rsp_way_oh[rsp_way]);
  // R3
  hit_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit == (rsp_way_oh != '0)));
  // R6
  miss_not_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> !rsp_dirty);
  // R9
  sweep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!lk_ready && !fill_ready));
  // R9
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(inv_all));
  // R11
  lookup_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !fill_ready);
endmodule

bind cache_tag_dir cache_tag_dir_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .fill_ready(fill_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_way_oh(rsp_way_oh), .rsp_way(rsp_way), .rsp_dirty(rsp_dirty),
  .inv_all(inv_all), .busy(busy)
);

// File: tb/cache_tag_dir_tb.sv
module cache_tag_dir_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_copyback = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_ready;
  logic        rsp_valid, rsp_hit, rsp_dirty;
  logic [3:0]  rsp_way_oh;
  logic [1:0]  rsp_way;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [1:0]  fill_way = '0;
  logic        fill_ready;
  logic        inv_all = 1'b0;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  cache_tag_dir u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .lk_write(lk_write), .lk_copyback(lk_copyback),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way_oh(rsp_way_oh),
    .rsp_way(rsp_way), .rsp_dirty(rsp_dirty),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_way(fill_way), .inv_all(inv_all), .busy(busy)
  );

  function automatic logic [31:0] mk(input logic [19:0] tag, input logic [7:0] idx,
                                     input logic [3:0] off);
    return {tag, idx, off};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [31:0] a, input logic [1:0] w);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_way = w;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // Issues one lookup and checks the full response.
  task automatic expect_lk(input string req, input logic [31:0] a, input logic wr,
                           input logic cb, input logic e_hit, input logic [1:0] e_way,
                           input logic e_dirty);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_write = wr; lk_copyback = cb;
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0; lk_copyback = 1'b0;
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"}, 32'(rsp_hit), 32'(e_hit));
    check({req, " way_oh"}, 32'(rsp_way_oh), e_hit ? 32'(4'b1 << e_way) : 32'd0);
    check({req, " way"}, 32'(rsp_way), e_hit ? 32'(e_way) : 32'd0);
    check({req, " dirty"}, 32'(rsp_dirty), 32'(e_dirty));
  endtask

  task automatic t_reset;
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R10 lk_ready", 32'(lk_ready), 32'd1);
    expect_lk("R10 empty", mk(20'h00000, 8'h00, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    expect_lk("R10 empty2", mk(20'hABCDE, 8'h37, 4'h8), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_fields;
    do_fill(mk(20'h12345, 8'h21, 4'h0), 2'd2);
    expect_lk("R5 fill hit", mk(20'h12345, 8'h21, 4'h0), 1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
    expect_lk("R1 offset", mk(20'h12345, 8'h21, 4'hC), 1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
    expect_lk("R1 other set", mk(20'h12345, 8'h20, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    expect_lk("R2 tag lsb", mk(20'h12344, 8'h21, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    expect_lk("R2 tag msb", mk(20'h92345, 8'h21, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    // R4: pulse lasts one cycle
    @(negedge clk);
    check("R4 single pulse", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_all_ways;
    for (int w = 0; w < 4; w++) do_fill(mk(20'hF0000 + 20'(w), 8'hFF, 4'h0), 2'(w));
    for (int w = 0; w < 4; w++)
      expect_lk("R3 way", mk(20'hF0000 + 20'(w), 8'hFF, 4'h4), 1'b0, 1'b0, 1'b1, 2'(w), 1'b0);
    do_fill(mk(20'hFFFFF, 8'hFF, 4'h0), 2'd3);
    expect_lk("R2 all ones", mk(20'hFFFFF, 8'hFF, 4'hF), 1'b0, 1'b0, 1'b1, 2'd3, 1'b0);
    expect_lk("R5 replaced", mk(20'hF0003, 8'hFF, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_writes;
    logic [31:0] a;
    a = mk(20'h0BEEF, 8'h40, 4'h0);
    do_fill(a, 2'd1);
    expect_lk("R7 wt clean", a, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
    expect_lk("R7 wt clean read", a, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
    expect_lk("R6 cb write", a, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1);
    expect_lk("R6 cb persists", a, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1);
    expect_lk("R7 wt dirty", a, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1);
    expect_lk("R6 read after wt", a, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1);
    do_fill(a, 2'd1);
    expect_lk("R5 refill cleans", a, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
    expect_lk("R8 write miss", mk(20'h0BEEE, 8'h40, 4'h0), 1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
    expect_lk("R8 still miss", mk(20'h0BEEE, 8'h40, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    expect_lk("R8 neighbour clean", a, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
  endtask

  task automatic t_priority;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(20'h00077, 8'h05, 4'h0);
    fill_valid = 1'b1; fill_addr = mk(20'h00077, 8'h05, 4'h0); fill_way = 2'd0;
    #1;
    check("R11 fill_ready", 32'(fill_ready), 32'd0);
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    check("R11 lookup taken", 32'(rsp_valid), 32'd1);
    expect_lk("R11 fill held off", mk(20'h00077, 8'h05, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_invalidate;
    int busy_cycles = 0;
    int blocked_bad = 0;
    do_fill(mk(20'h55555, 8'h10, 4'h0), 2'd0);
    expect_lk("R9 pre", mk(20'h55555, 8'h10, 4'h0), 1'b1, 1'b1, 1'b1, 2'd0, 1'b1);
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    while (busy && busy_cycles < 1000) begin
      busy_cycles++;
      if (lk_ready || fill_ready) blocked_bad++;
      @(negedge clk);
    end
    check("R9 busy length", 32'(busy_cycles), 32'd256);
    check("R9 ready low", 32'(blocked_bad), 32'd0);
    check("R9 ready back", 32'(lk_ready), 32'd1);
    expect_lk("R9 cleared", mk(20'h55555, 8'h10, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    expect_lk("R9 cleared top set", mk(20'hFFFFF, 8'hFF, 4'h0), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
    do_fill(mk(20'h55555, 8'h10, 4'h0), 2'd2);
    expect_lk("R9 clean after refill", mk(20'h55555, 8'h10, 4'h0), 1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_all_ways();
    t_writes();
    t_priority();
    t_invalidate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule